// File: doc/BRIEF.md
# MDIO Management Shift Engine

This block runs one station-management transaction on an MDIO bus for each word the host writes. The host word holds start bits, opcode, PHY address, register address, turnaround and a 16-bit data field. Accepting the word starts the operation. The block generates MDC from the bus clock through a programmable divider. It sends a run of preamble ones, then shifts the word out MSB first. While it shifts, the same register takes PHY input bits in at its LSB.

The frame is built by rotating the register the host reads. A read during an operation therefore shows a partly rotated word. When the operation ends, every bit is back in its starting position. After a read frame, the turnaround and data fields hold what the PHY drove. Completion clears the busy state, raises the idle flag and pulses an interrupt for one cycle. Bit 30 of the word selects the frame flavour, and the block uses it only to decide whether the frame is a read.

Top module: `mdio_shift_engine`

## Requirements
- R1: After reset, `mgmt_idle` is 1, `mgmt_irq`, `mdc` and `mdio_oe` are 0, and `mgmt_rdata` is 0.
- R2: A write while idle loads the word and starts an operation. In the next cycle `mgmt_idle` is 0 and `mgmt_rdata` equals the written word.
- R3: MDC stays low while idle. Each MDC half period lasts `mdc_half` bus cycles, and a value of 0 counts as 1. `mdc_half` must stay stable during an operation. With the default preamble, `mgmt_idle` returns exactly 128×half bus cycles after the accepting clock edge, and MDC is low again at that point.
- R4: During the first 32 MDC cycles of a frame, `mdio_o` is 1 and `mdio_oe` is 1 at every MDC rising edge.
- R5: After the preamble, the 32 register bits go out MSB first, one per MDC cycle. `mdio_o` changes only after an MDC falling edge or when an operation starts.
- R6: After a non-read frame completes, `mgmt_rdata` equals the word that was written.
- R7: Read detection depends on bit 30. When bit 30 is 1, the frame is a read only if bits [29:28] are 2'b10. When bit 30 is 0, the frame is a read whenever bit 29 is 1. In a read frame, `mdio_oe` drops for the last 18 register slots (bits 17 down to 0). It is not raised again before the operation ends.
- R8: After a read frame, bits [31:18] hold their written values. Bits [17:0] hold the `mdio_i` values sampled at the MDC rising edges of those 18 slots, first sample in bit 17.
- R9: During an operation, once n register bits have been shifted in a non-read frame, `mgmt_rdata` equals the written word rotated left by n.
- R10: A write that arrives during an operation is ignored. It changes neither the final word nor the length of the operation.
- R11: `mgmt_irq` is high for exactly one cycle per operation, in the same cycle that `mgmt_idle` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mgmt_wr | input | 1 | Write strobe for the management word |
| mgmt_wdata | input | 32 | Management word to load |
| mgmt_rdata | output | 32 | Current register contents |
| mgmt_idle | output | 1 | High when no operation is running |
| mgmt_irq | output | 1 | One-cycle completion pulse |
| mdc_half | input | DIV_W | MDC half period in bus cycles (0 acts as 1) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input data |

## Verification
Assertions watch several properties on every cycle:
- MDC is low when idle, and the divider count stays inside the programmed half period.
- `mdio_o` holds steady between MDC falling edges.
- The output enable is never raised in the middle of a frame.
- A write during an operation leaves the register untouched.
- The completion pulse lasts one cycle and coincides with the end of the busy state.

Some behaviour needs the bench scenarios instead:
- The preamble length and the MSB-first bit order.
- Where the output enable drops for read frames of each flavour.
- That PHY bits land in the right field and the other bits return home.
- The rotated view partway through a frame.
- The exact operation length for several divider settings, including zero.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   // register geometry
   localparam int MGMT_W      = 32;
   localparam int PRE_LEN     = 32;
   localparam int FRAME_SLOTS = PRE_LEN + MGMT_W;
   // field positions the read decode relies on
   localparam int FLAVOUR_BIT = 30;
   localparam int OP_HI       = 29;
   localparam int OP_LO       = 28;
   localparam int TA_HI       = 17;
   // register slot (0 = MSB) from which a read releases the line
   localparam int REL_SLOT    = MGMT_W - 1 - TA_HI;

   function automatic logic frame_is_read(input logic [MGMT_W-1:0] w);
      if (w[FLAVOUR_BIT])
         return (w[OP_HI:OP_LO] == 2'b10);
      else
         return w[OP_HI];
   endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half_cfg,
   output logic             mdc,
   output logic             rise_tick,
   output logic             fall_tick
);
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] half_m1;
   logic             tog;
   logic             mdc_q;

   assign half_m1   = (half_cfg == '0) ? '0 : half_cfg - DIV_W'(1);
   assign tog       = run && (cnt_q == half_m1);
   assign rise_tick = tog && !mdc_q;
   assign fall_tick = tog && mdc_q;
   assign mdc       = mdc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (tog) begin
         cnt_q <= '0;
         mdc_q <= ~mdc_q;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end

   // R3
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q <= half_m1));
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
   import mdio_pkg::*;
#(
   parameter bit PREAMBLE_ON = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [MGMT_W-1:0] wr_data,
   input  logic              rise_tick,
   input  logic              fall_tick,
   input  logic              mdio_i,
   output logic              busy,
   output logic [MGMT_W-1:0] shift_q,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic              done_pulse
);
   localparam int SLOT_W   = $clog2(FRAME_SLOTS);
   localparam int REG_BASE = FRAME_SLOTS - MGMT_W;

   logic [SLOT_W-1:0] slot_q;
   logic [SLOT_W-1:0] start_slot;
   logic              first_bit;
   logic              rd_q;
   logic [SLOT_W-1:0] nxt_slot;
   logic [SLOT_W-1:0] nxt_rel;
   logic              in_reg_now;
   logic              nxt_in_reg;
   logic              nxt_released;
   logic              last_slot;

   // variant: with preamble the frame starts on slot 0, else on the first register slot
   generate
      if (PREAMBLE_ON) begin : g_pre
         assign start_slot = '0;
         assign first_bit  = 1'b1;
      end else begin : g_nopre
         assign start_slot = SLOT_W'(REG_BASE);
         assign first_bit  = wr_data[MGMT_W-1];
      end
   endgenerate

   assign nxt_slot     = slot_q + SLOT_W'(1);
   assign nxt_rel      = nxt_slot - SLOT_W'(REG_BASE);
   assign in_reg_now   = (slot_q >= SLOT_W'(REG_BASE));
   assign nxt_in_reg   = (nxt_slot >= SLOT_W'(REG_BASE));
   assign nxt_released = rd_q && nxt_in_reg && (nxt_rel >= SLOT_W'(REL_SLOT));
   assign last_slot    = (slot_q == SLOT_W'(FRAME_SLOTS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shift_q    <= '0;
         busy       <= 1'b0;
         slot_q     <= '0;
         mdio_o     <= 1'b0;
         mdio_oe    <= 1'b0;
         rd_q       <= 1'b0;
         done_pulse <= 1'b0;
      end else begin
         done_pulse <= 1'b0;
         if (!busy) begin
            if (wr_en) begin
               shift_q <= wr_data;
               busy    <= 1'b1;
               slot_q  <= start_slot;
               mdio_o  <= first_bit;
               mdio_oe <= 1'b1;
               rd_q    <= frame_is_read(wr_data);
            end
         end else begin
            if (rise_tick && in_reg_now)
               shift_q <= {shift_q[MGMT_W-2:0], mdio_oe ? shift_q[MGMT_W-1] : mdio_i};
            if (fall_tick) begin
               if (last_slot) begin
                  busy       <= 1'b0;
                  done_pulse <= 1'b1;
                  mdio_oe    <= 1'b0;
                  mdio_o     <= 1'b0;
               end else begin
                  slot_q  <= nxt_slot;
                  mdio_o  <= nxt_in_reg ? shift_q[MGMT_W-1] : 1'b1;
                  mdio_oe <= !nxt_released;
               end
            end
         end
      end
   end

   // R5
   mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fall_tick) |=> $stable(mdio_o));
   // R7
   oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdio_oe) |-> $past(!busy));
   // R10
   busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_en && !rise_tick) |=> $stable(shift_q));
   // R11
   done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> !done_pulse);
   // R11
   done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> (!busy && $past(busy)));
endmodule

// File: rtl/mdio_shift_engine.sv
module mdio_shift_engine
   import mdio_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter bit PREAMBLE_ON = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mgmt_wr,
   input  logic [MGMT_W-1:0] mgmt_wdata,
   output logic [MGMT_W-1:0] mgmt_rdata,
   output logic              mgmt_idle,
   output logic              mgmt_irq,
   input  logic [DIV_W-1:0]  mdc_half,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("mdio_shift_engine: DIV_W must be within 1..16");
      end
   endgenerate

   logic busy;
   logic rise_tick;
   logic fall_tick;

   mdio_clk_div #(.DIV_W(DIV_W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy),
      .half_cfg  (mdc_half),
      .mdc       (mdc),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick)
   );

   mdio_frame_shifter #(.PREAMBLE_ON(PREAMBLE_ON)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (mgmt_wr),
      .wr_data    (mgmt_wdata),
      .rise_tick  (rise_tick),
      .fall_tick  (fall_tick),
      .mdio_i     (mdio_i),
      .busy       (busy),
      .shift_q    (mgmt_rdata),
      .mdio_o     (mdio_o),
      .mdio_oe    (mdio_oe),
      .done_pulse (mgmt_irq)
   );

   assign mgmt_idle = !busy;

   // R3
   mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mgmt_idle |-> !mdc);
   // R2
   idle_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mgmt_idle) |-> $past(mgmt_wr));
endmodule

// File: tb/sim_mdio_shift_engine.sv
module sim_mdio_shift_engine;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 6;
   // [56:25] word, [24:7] PHY response bits, [6:3] half, [2] read, [1] rotate probe, [0] busy write
   localparam logic [56:0] VEC [NVEC] = '{
      {32'h5192A5C3, 18'h00000, 4'd1, 1'b0, 1'b1, 1'b0},
      {32'h6F880000, 18'h23C5A, 4'd2, 1'b1, 1'b0, 1'b0},
      {32'h30840000, 18'h2BEEF, 4'd1, 1'b1, 1'b0, 1'b0},
      {32'h20840000, 18'h20001, 4'd3, 1'b1, 1'b0, 1'b0},
      {32'h70841234, 18'h00000, 4'd1, 1'b0, 1'b1, 1'b0},
      {32'h00849999, 18'h00000, 4'd0, 1'b0, 1'b0, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mgmt_wr = 1'b0;
   logic [31:0] mgmt_wdata = '0;
   logic [31:0] mgmt_rdata;
   logic        mgmt_idle;
   logic        mgmt_irq;
   logic [7:0]  mdc_half = 8'd1;
   logic        mdc;
   logic        mdio_o;
   logic        mdio_oe;
   logic        mdio_i = 1'b1;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mdio_shift_engine u0 (
      .clk(clk), .rst_n(rst_n), .mgmt_wr(mgmt_wr), .mgmt_wdata(mgmt_wdata),
      .mgmt_rdata(mgmt_rdata), .mgmt_idle(mgmt_idle), .mgmt_irq(mgmt_irq),
      .mdc_half(mdc_half), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
      .mdio_i(mdio_i)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic run_vec(input logic [56:0] v);
      logic [31:0] w;
      logic [17:0] resp;
      logic [3:0]  half;
      logic        rd, probe, intrude;
      logic [31:0] final_exp;
      int k, nrise, irqs, exp_cyc;
      bit prev, pre_ok, bit_ok, oe_ok;
      w = v[56:25]; resp = v[24:7]; half = v[6:3];
      rd = v[2]; probe = v[1]; intrude = v[0];
      final_exp = rd ? {w[31:18], resp} : w;
      exp_cyc = 128 * ((half == 4'd0) ? 1 : int'(half));
      @(negedge clk);
      mdc_half = {4'd0, half};
      mgmt_wdata = w;
      mgmt_wr = 1'b1;
      mdio_i = 1'b1;
      @(negedge clk);
      mgmt_wr = 1'b0;
      check(!mgmt_idle && mgmt_rdata == w, "R2", "start", mgmt_rdata, w);
      k = 0; nrise = 0; irqs = 0; prev = mdc;
      pre_ok = 1'b1; bit_ok = 1'b1; oe_ok = 1'b1;
      while (!mgmt_idle && k < 20000) begin
         @(negedge clk);
         k++;
         if (mgmt_irq) irqs++;
         mgmt_wr = 1'b0;
         if (mdc && !prev) begin
            if (nrise < 32) begin
               if (!(mdio_o && mdio_oe)) pre_ok = 1'b0;
            end else begin
               int i;
               bit exp_oe;
               i = nrise - 32;
               exp_oe = !(rd && i >= 14);
               if (mdio_oe !== exp_oe) oe_ok = 1'b0;
               if (exp_oe && mdio_o !== w[31-i]) bit_ok = 1'b0;
            end
            nrise++;
            if (probe && nrise == 40)
               check(mgmt_rdata == {w[23:0], w[31:24]}, "R9", "rotated view",
                     mgmt_rdata, {w[23:0], w[31:24]});
            if (intrude && nrise == 10) begin
               mgmt_wdata = ~w;
               mgmt_wr = 1'b1;
            end
         end
         mdio_i = (nrise >= 46 && nrise < 64) ? resp[63-nrise] : 1'b1;
         prev = mdc;
      end
      check(k == exp_cyc, "R3", "op length", k, exp_cyc);
      check(mgmt_irq == 1'b1, "R11", "irq with idle", {31'd0, mgmt_irq}, 32'd1);
      check(pre_ok && nrise == 64, "R4", "preamble", nrise, 64);
      check(bit_ok, "R5", "bit order", {31'd0, bit_ok}, 32'd1);
      check(oe_ok, "R7", "oe pattern", {31'd0, oe_ok}, 32'd1);
      if (rd) check(mgmt_rdata == final_exp, "R8", "read capture", mgmt_rdata, final_exp);
      else if (intrude) check(mgmt_rdata == final_exp, "R10", "busy write", mgmt_rdata, final_exp);
      else check(mgmt_rdata == final_exp, "R6", "restore", mgmt_rdata, final_exp);
      @(negedge clk);
      if (mgmt_irq) irqs++;
      check(irqs == 1, "R11", "irq count", irqs, 1);
      check(!mdc && mgmt_idle, "R3", "mdc idle low", {31'd0, mdc}, 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog all-requirements actual=expired expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(mgmt_idle == 1'b1, "R1", "idle", {31'd0, mgmt_idle}, 32'd1);
      check(mgmt_irq == 1'b0, "R1", "irq", {31'd0, mgmt_irq}, 32'd0);
      check(mdc == 1'b0, "R1", "mdc", {31'd0, mdc}, 32'd0);
      check(mdio_oe == 1'b0, "R1", "oe", {31'd0, mdio_oe}, 32'd0);
      check(mgmt_rdata == 32'd0, "R1", "rdata", mgmt_rdata, 32'd0);
      for (int n = 0; n < NVEC; n++) run_vec(VEC[n]);
      // directed: reset in the middle of an operation returns to the R1 state
      @(negedge clk);
      mgmt_wdata = 32'h5192A5C3;
      mgmt_wr = 1'b1;
      @(negedge clk);
      mgmt_wr = 1'b0;
      repeat (20) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(mgmt_idle && !mdc && !mdio_oe && mgmt_rdata == 0, "R1", "mid-op reset",
            mgmt_rdata, 32'd0);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule